// File: doc/BRIEF.md
# Processor Sleep and Wake Controller

This block decides when a small processor core may stop its clock and how deep that stop goes. The core hands it a wait-for-interrupt or wait-for-event request, a send-event pulse and an exception-return strobe. It also sees the pending and enable vectors of the interrupt lines, an external event input and three control bits: deep-sleep select, sleep-on-exit and pending-as-event. From these the block drives a core clock-halt line and a deep-sleep request to the clock and power unit. It also gives a one-cycle wake pulse and the state of a sticky event flag.

Light sleep stops only the core clock, and the core restarts one cycle after the wake condition is seen. Deep sleep also asks the power unit to stop the main clocks. On wake the block withdraws that request at once, then holds the core clock off until the clock unit reports that its oscillator has settled. The sticky event flag lets an event that arrives while the core is running make a later wait-for-event return without sleeping.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset, core_clk_halt, deep_sleep_req, wake_pulse and event_latched are all 0.
- R2: A wfi_req while running sets core_clk_halt. Light sleep ends when some line has both irq_pending and irq_enable set. A line that is pending but disabled does not end it. core_clk_halt falls in the cycle after the wake condition is present.
- R3: A wfe_req while running, with the event flag clear and no event in that cycle, sets core_clk_halt. The sleep ends on sev_pulse, on ext_event, or on an enabled pending line. An event that ends this sleep does not set event_latched.
- R4: Any event seen while the block is not in a wait-for-event sleep sets event_latched, and the flag stays set. A wfe_req that finds the flag set, or that coincides with an event, clears the flag and does not halt the core.
- R5: With scr_sevonpend set, a 0-to-1 change of any irq_pending bit is an event, whether the line is enabled or not. A line that stays pending is not a new event. With scr_sevonpend clear, a disabled line never produces an event.
- R6: scr_deepsleep is sampled when sleep is entered. If it is 1, deep_sleep_req stays high for the whole sleep. If it is 0, only core_clk_halt rises.
- R7: In deep sleep, deep_sleep_req falls combinationally in the cycle the wake condition is present. core_clk_halt stays high until clk_ready is sampled high, and falls in the next cycle.
- R8: exc_return with scr_sleep_on_exit set puts the running core to sleep with wait-for-interrupt wake rules, and the depth follows scr_deepsleep. With scr_sleep_on_exit clear, exc_return has no effect.
- R9: wake_pulse is high for exactly one cycle: the first cycle in which core_clk_halt is low after a sleep.
- R10: wfi_req, wfe_req and exc_return are ignored while the core is halted. The wake rule chosen at entry stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi_req | input | 1 | Wait-for-interrupt request from the core |
| wfe_req | input | 1 | Wait-for-event request from the core |
| sev_pulse | input | 1 | Send-event pulse |
| ext_event | input | 1 | External event input |
| irq_pending | input | NIRQ | Pending state of each interrupt line |
| irq_enable | input | NIRQ | Enable of each interrupt line |
| exc_return | input | 1 | Return from the last active exception |
| scr_deepsleep | input | 1 | Select deep sleep for the next entry |
| scr_sleep_on_exit | input | 1 | Re-enter sleep on exception return |
| scr_sevonpend | input | 1 | Treat newly pending lines as events |
| clk_ready | input | 1 | Main clocks settled after deep sleep |
| core_clk_halt | output | 1 | Stop the core clock |
| deep_sleep_req | output | 1 | Request main-clock shutdown |
| wake_pulse | output | 1 | One-cycle pulse when the core resumes |
| event_latched | output | 1 | Sticky event flag |

## Verification
The hardest states to reach are the ones where two rules overlap in a single cycle. Examples are an event that arrives in the same cycle as a wait-for-event request, and a line that has stayed pending since before a wait-for-event with pending-as-event enabled. Both depend on how long an input has already been held. The bench produces them by holding a disabled line pending across the earlier consuming wait-for-event, and by driving the event and the request on the same clock edge. Each wake source is swept at both sleep depths. Deep wakes keep clk_ready low for an extra cycle, which exposes the relock hold.

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl #(
  parameter int NIRQ = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wfi_req,
  input  logic            wfe_req,
  input  logic            sev_pulse,
  input  logic            ext_event,
  input  logic [NIRQ-1:0] irq_pending,
  input  logic [NIRQ-1:0] irq_enable,
  input  logic            exc_return,
  input  logic            scr_deepsleep,
  input  logic            scr_sleep_on_exit,
  input  logic            scr_sevonpend,
  input  logic            clk_ready,
  output logic            core_clk_halt,
  output logic            deep_sleep_req,
  output logic            wake_pulse,
  output logic            event_latched
);

  typedef enum logic [1:0] {S_RUN, S_LIGHT, S_DEEP, S_RELOCK} st_t;

  st_t            st, st_n;
  logic           wfe_mode, wfe_mode_n;
  logic           latch, latch_n;
  logic           wake_q;
  logic [NIRQ-1:0] pend_q;

  wire irq_take  = |(irq_pending & irq_enable);
  wire pend_rise = |(irq_pending & ~pend_q);
  wire ev        = sev_pulse | ext_event | irq_take | (scr_sevonpend & pend_rise);
  wire asleep    = (st == S_LIGHT) || (st == S_DEEP);
  wire wake      = asleep && (wfe_mode ? ev : irq_take);
  wire running   = (st == S_RUN);
  wire go_wfi    = running && (wfi_req || (!wfe_req && exc_return && scr_sleep_on_exit));
  wire go_wfe    = running && !wfi_req && wfe_req;
  wire st_t_deep = scr_deepsleep;

  always_comb begin
    st_n       = st;
    wfe_mode_n = wfe_mode;
    latch_n    = latch | ev;
    unique case (st)
      S_RUN: begin
        if (go_wfi) begin
          st_n       = st_t_deep ? S_DEEP : S_LIGHT;
          wfe_mode_n = 1'b0;
        end else if (go_wfe) begin
          latch_n = 1'b0;
          if (!(latch || ev)) begin
            st_n       = st_t_deep ? S_DEEP : S_LIGHT;
            wfe_mode_n = 1'b1;
          end
        end
      end
      S_LIGHT:  if (wake) st_n = S_RUN;
      S_DEEP:   if (wake) st_n = S_RELOCK;
      S_RELOCK: if (clk_ready) st_n = S_RUN;
      default:  st_n = S_RUN;
    endcase
    if (asleep && wfe_mode) latch_n = latch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_RUN;
      wfe_mode <= 1'b0;
      latch    <= 1'b0;
      wake_q   <= 1'b0;
      pend_q   <= '0;
    end else begin
      st       <= st_n;
      wfe_mode <= wfe_mode_n;
      latch    <= latch_n;
      wake_q   <= !running && (st_n == S_RUN);
      pend_q   <= irq_pending;
    end
  end

  assign core_clk_halt  = !running;
  assign deep_sleep_req = (st == S_DEEP) && !wake;
  assign wake_pulse     = wake_q;
  assign event_latched  = latch;

  assert_deep_needs_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    deep_sleep_req |-> core_clk_halt);

  assert_wake_while_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> !core_clk_halt);

  assert_wake_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  assert_relock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RELOCK && !clk_ready) |=> core_clk_halt);

  assert_wfe_consume_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !wfi_req && wfe_req && latch) |=> (!core_clk_halt && !event_latched));

  assert_wfi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LIGHT && !wfe_mode && !irq_take) |=> core_clk_halt);

  assert_ignore_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !wake) |=> (core_clk_halt && $stable(wfe_mode)));

endmodule

// File: tb/sleep_wake_ctrl_test.sv
module sleep_wake_ctrl_test;
  localparam int N = 4;

  logic clk = 0, rst_n = 0;
  logic wfi_req = 0, wfe_req = 0, sev_pulse = 0, ext_event = 0, exc_return = 0;
  logic [N-1:0] irq_pending = '0, irq_enable = '0;
  logic scr_deepsleep = 0, scr_sleep_on_exit = 0, scr_sevonpend = 0, clk_ready = 0;
  logic core_clk_halt, deep_sleep_req, wake_pulse, event_latched;
  int checks = 0, errors = 0;

  sleep_wake_ctrl #(.NIRQ(N)) uut (
    .clk(clk), .rst_n(rst_n), .wfi_req(wfi_req), .wfe_req(wfe_req),
    .sev_pulse(sev_pulse), .ext_event(ext_event), .irq_pending(irq_pending),
    .irq_enable(irq_enable), .exc_return(exc_return), .scr_deepsleep(scr_deepsleep),
    .scr_sleep_on_exit(scr_sleep_on_exit), .scr_sevonpend(scr_sevonpend),
    .clk_ready(clk_ready), .core_clk_halt(core_clk_halt), .deep_sleep_req(deep_sleep_req),
    .wake_pulse(wake_pulse), .event_latched(event_latched));

  always #5 clk = ~clk;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk); #1;
  endtask

  task automatic enter(int kind, int deep);
    scr_deepsleep = deep[0];
    case (kind)
      0: wfi_req = 1;
      1: wfe_req = 1;
      default: begin scr_sleep_on_exit = 1; exc_return = 1; end
    endcase
    tick;
    wfi_req = 0; wfe_req = 0; exc_return = 0;
    chk("R6 halt on entry", core_clk_halt, 1);
    chk("R6 deep request level", deep_sleep_req, deep);
  endtask

  task automatic wake_seq(int deep, int exp_latch);
    #1;
    chk("R7 deep request drops at wake", deep_sleep_req, 0);
    chk("R7 halt still high at wake", core_clk_halt, 1);
    tick;
    sev_pulse = 0; ext_event = 0; irq_pending = '0;
    if (deep != 0) begin
      chk("R7 relock halt", core_clk_halt, 1);
      tick;
      chk("R7 halt without ready", core_clk_halt, 1);
      clk_ready = 1;
      tick;
      clk_ready = 0;
    end
    chk("R2 halt released", core_clk_halt, 0);
    chk("R9 wake pulse high", wake_pulse, 1);
    tick;
    chk("R9 wake pulse single", wake_pulse, 0);
    chk("R4 flag after wake", event_latched, exp_latch);
  endtask

  task automatic consume;
    wfe_req = 1;
    tick;
    wfe_req = 0;
    chk("R4 consuming wfe no halt", core_clk_halt, 0);
    chk("R4 flag cleared", event_latched, 0);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick; tick;
    chk("R1 halt reset", core_clk_halt, 0);
    chk("R1 deep reset", deep_sleep_req, 0);
    chk("R1 wake reset", wake_pulse, 0);
    chk("R1 flag reset", event_latched, 0);
    rst_n = 1;
    tick;

    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < N; i++) begin
        irq_enable = N'(1 << i);
        enter(0, d);
        irq_pending = ~N'(1 << i);
        tick; tick;
        chk("R2 disabled line keeps sleep", core_clk_halt, 1);
        chk("R5 no event without pending-as-event", event_latched, 0);
        irq_pending = '1;
        wake_seq(d, 1);
        consume;
      end
    end

    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 3; s++) begin
        irq_enable = 4'b0001;
        enter(1, d);
        chk("R3 flag clear in wfe sleep", event_latched, 0);
        tick;
        chk("R3 wfe stays asleep", core_clk_halt, 1);
        case (s)
          0: sev_pulse = 1;
          1: ext_event = 1;
          default: irq_pending = 4'b0001;
        endcase
        wake_seq(d, 0);
      end
    end

    irq_enable = '0;
    sev_pulse = 1; tick; sev_pulse = 0;
    chk("R4 flag set by sev", event_latched, 1);
    tick; tick; tick;
    chk("R4 flag sticky", event_latched, 1);
    consume;
    ext_event = 1; tick; ext_event = 0;
    chk("R4 flag set by ext", event_latched, 1);
    consume;
    sev_pulse = 1; wfe_req = 1; tick; sev_pulse = 0; wfe_req = 0;
    chk("R4 same-cycle event no halt", core_clk_halt, 0);
    chk("R4 same-cycle event consumed", event_latched, 0);

    scr_sevonpend = 1;
    for (int d = 0; d < 2; d++) begin
      enter(1, d);
      irq_pending = 4'b0100;
      wake_seq(d, 0);
    end
    enter(0, 0);
    irq_pending = 4'b0010;
    tick; tick;
    chk("R5 disabled rise keeps wfi sleep", core_clk_halt, 1);
    chk("R5 disabled rise sets flag", event_latched, 1);
    irq_enable = 4'b0010;
    wake_seq(0, 1);
    consume;
    irq_enable = '0;
    irq_pending = 4'b1000; tick;
    chk("R5 rise sets flag while running", event_latched, 1);
    consume;
    enter(1, 0);
    tick; tick;
    chk("R5 held pending is not new event", core_clk_halt, 1);
    sev_pulse = 1;
    wake_seq(0, 0);
    scr_sevonpend = 0;

    exc_return = 1; tick; exc_return = 0;
    chk("R8 exit without bit no halt", core_clk_halt, 0);
    for (int d = 0; d < 2; d++) begin
      irq_enable = 4'b0100;
      enter(2, d);
      sev_pulse = 1; tick; sev_pulse = 0;
      tick;
      chk("R8 exit sleep ignores sev", core_clk_halt, 1);
      irq_pending = 4'b0100;
      wake_seq(d, 1);
      consume;
      scr_sleep_on_exit = 0;
    end

    irq_enable = 4'b0001;
    enter(0, 0);
    wfe_req = 1; tick; wfe_req = 0;
    sev_pulse = 1; tick; sev_pulse = 0;
    tick;
    chk("R10 wfe while halted ignored", core_clk_halt, 1);
    exc_return = 1; scr_deepsleep = 1; tick; exc_return = 0;
    chk("R10 no deep request change", deep_sleep_req, 0);
    irq_pending = 4'b0001;
    wake_seq(0, 1);
    consume;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule